// File: doc/BRIEF.md
# Bus Reset and Boot Sequencer

This block is the agent side of a system-bus reset. It watches an active-low bus reset line and brings it into its own clock domain through two flip-flops. While that reset is held, it pulls every bus output low. Each time it sees the reset become active, including the reset already held at power-up, it emits a one-cycle pulse that invalidates the L1 cache without write-back.

When it sees the reset released, it captures the configuration straps and the init strap in the same cycle. From these it picks one of three paths:

- **Float:** it stays off the bus.
- **Self-test:** it starts the built-in self-test and waits for the self-test to report completion.
- **Direct boot:** it starts the first fetch at once.

Every path that drives the bus ends with a one-cycle fetch strobe, with the fixed high reset vector on the address output. A hold counter measures how long each reset was held. A release that comes too early raises an error flag. The self-test engine and the bus transactions are outside this block; the self-test is stood in for by a done input.

Top module: `bus_reset_sequencer`

## Requirements
- R1: `bus_rst_ni` may be low at two consecutive rising edges of `clk_i`. From the second of those edges, `drive_en_o`, `bist_start_o` and `fetch_start_o` are all 0.
- R2: `bus_rst_ni` may fall, or may already be low when `rst_ni` releases. `l1_inval_o` is then high for exactly one cycle, after the third rising edge from the fall.
- R3: `cfg_o` takes `cfg_strap_i` in the cycle the reset release is acted on. After that it keeps the value, whatever the straps do, until the next release.
- R4: The float option is `cfg_strap_i` bit 0 = 1. When it is captured at release, `drive_en_o` stays 0 and neither `bist_start_o` nor `fetch_start_o` pulses.
- R5: The self-test path is taken when `init_strap_i` = 1 and bit 0 = 0 at release. `bist_start_o` pulses once, and `fetch_start_o` pulses only after a later edge samples `bist_done_i` high.
- R6: The direct path is taken when `init_strap_i` = 0 and bit 0 = 0 at release. `fetch_start_o` pulses for one cycle after the third rising edge from the release of `bus_rst_ni`.
- R7: Whenever `fetch_start_o` is 1, `fetch_addr_o` equals `RST_VEC` (default 32'hFFFF_FFF0). On every non-float path, `drive_en_o` is 1 from the release decision onwards.
- R8: `bus_rst_ni` may be held low for fewer than `MIN_HOLD_CYC` clock cycles. `short_rst_err_o` is then 1 after release. A release after a hold at least that long clears it.
- R9: Reasserting `bus_rst_ni` during the self-test wait or during run cancels the boot. No fetch follows, even when `bist_done_i` is high in the cycle the reassertion is acted on.
- R10: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| bus_rst_ni | input | 1 | Monitored active-low bus reset, asynchronous |
| init_strap_i | input | 1 | Strap that selects the self-test path |
| cfg_strap_i | input | CFG_W | Configuration straps; bit 0 selects float |
| bist_done_i | input | 1 | Self-test completion |
| drive_en_o | output | 1 | Bus output enable |
| bist_start_o | output | 1 | Self-test start pulse |
| l1_inval_o | output | 1 | Cache invalidate pulse |
| fetch_start_o | output | 1 | First fetch strobe |
| fetch_addr_o | output | ADDR_W | First fetch address |
| cfg_o | output | CFG_W | Captured straps |
| short_rst_err_o | output | 1 | Reset-too-short flag |

## Verification
Two events can land in the same cycle: a reassertion of the bus reset and the self-test completion that would launch the fetch. The bench provokes this by dropping `bus_rst_ni` while the sequencer waits on self-test. It then raises `bist_done_i` just before the edge at which the sequencer acts on the reassertion. The scoreboard expects only the invalidate pulse, with no fetch strobe. It also expects the following release to boot cleanly on the direct path.

// File: rtl/bus_rst_pkg.sv
package bus_rst_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_FLOAT = 2'd1,
    ST_BIST = 2'd2,
    ST_RUN = 2'd3
  } boot_state_e;
endpackage

// File: rtl/rst_edge_sync.sv
module rst_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_rst_ni_i,
  output logic level_o,
  output logic assert_o,
  output logic release_o
);
  logic s1_q, s2_q, prev_q;

  // prev resets high so a reset held at power-up reads as an assertion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= async_rst_ni_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign level_o   = s2_q;
  assign assert_o  = prev_q & ~s2_q;
  assign release_o = ~prev_q & s2_q;
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int unsigned MIN_HOLD_CYC = 200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic short_o
);
  localparam int unsigned CNT_W = $clog2(MIN_HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_HOLD_CYC);

  logic [CNT_W-1:0] cnt_q;

  // the cycle that detects the assertion counts as the first held cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (start_i) cnt_q <= CNT_W'(1);
    else if (tick_i && cnt_q < LIMIT) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign short_o = cnt_q < LIMIT;
endmodule

// File: rtl/boot_fsm.sv
module boot_fsm
  import bus_rst_pkg::*;
#(
  parameter int unsigned CFG_W   = 4,
  parameter int unsigned TRI_BIT = 0,
  parameter int unsigned ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] RST_VEC = 32'hFFFF_FFF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              level_i,
  input  logic              assert_i,
  input  logic              release_i,
  input  logic              short_i,
  input  logic              init_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              bist_done_i,
  output logic              drive_en_o,
  output logic              bist_start_o,
  output logic              inval_o,
  output logic              fetch_start_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              err_o
);
  boot_state_e state_q;
  logic drive_q, bist_q, fetch_q, inval_q, err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      drive_q <= 1'b0;
      bist_q  <= 1'b0;
      fetch_q <= 1'b0;
      inval_q <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      cfg_q   <= '0;
    end else begin
      bist_q  <= 1'b0;
      fetch_q <= 1'b0;
      inval_q <= 1'b0;
      // reassertion wins over any boot step in the same cycle
      if (assert_i) begin
        state_q <= ST_HOLD;
        drive_q <= 1'b0;
        addr_q  <= '0;
        inval_q <= 1'b1;
      end else begin
        unique case (state_q)
          ST_HOLD: if (release_i) begin
            cfg_q <= cfg_i;
            err_q <= short_i;
            if (cfg_i[TRI_BIT]) begin
              state_q <= ST_FLOAT;
            end else begin
              drive_q <= 1'b1;
              if (init_i) begin
                state_q <= ST_BIST;
                bist_q  <= 1'b1;
              end else begin
                state_q <= ST_RUN;
                fetch_q <= 1'b1;
                addr_q  <= RST_VEC;
              end
            end
          end
          ST_BIST: if (bist_done_i) begin
            state_q <= ST_RUN;
            fetch_q <= 1'b1;
            addr_q  <= RST_VEC;
          end
          ST_FLOAT, ST_RUN: ;
          default: state_q <= ST_HOLD;
        endcase
      end
    end
  end

  // gating by the synced level removes bus drive one edge after it drops
  assign drive_en_o    = drive_q & level_i;
  assign bist_start_o  = bist_q & level_i;
  assign fetch_start_o = fetch_q & level_i;
  assign inval_o       = inval_q;
  assign fetch_addr_o  = addr_q;
  assign cfg_o         = cfg_q;
  assign err_o         = err_q;
endmodule

// File: rtl/bus_reset_sequencer.sv
module bus_reset_sequencer #(
  parameter int unsigned CFG_W        = 4,
  parameter int unsigned TRI_BIT      = 0,
  parameter int unsigned ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] RST_VEC = 32'hFFFF_FFF0,
  parameter int unsigned MIN_HOLD_CYC = 200000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rst_ni,
  input  logic              init_strap_i,
  input  logic [CFG_W-1:0]  cfg_strap_i,
  input  logic              bist_done_i,
  output logic              drive_en_o,
  output logic              bist_start_o,
  output logic              l1_inval_o,
  output logic              fetch_start_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              short_rst_err_o
);
  logic level, assert_det, release_det, short_hold;

  rst_edge_sync u_sync (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .async_rst_ni_i (bus_rst_ni),
    .level_o        (level),
    .assert_o       (assert_det),
    .release_o      (release_det)
  );

  hold_timer #(.MIN_HOLD_CYC(MIN_HOLD_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (assert_det),
    .tick_i  (~level),
    .short_o (short_hold)
  );

  boot_fsm #(
    .CFG_W(CFG_W), .TRI_BIT(TRI_BIT), .ADDR_W(ADDR_W), .RST_VEC(RST_VEC)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .level_i       (level),
    .assert_i      (assert_det),
    .release_i     (release_det),
    .short_i       (short_hold),
    .init_i        (init_strap_i),
    .cfg_i         (cfg_strap_i),
    .bist_done_i   (bist_done_i),
    .drive_en_o    (drive_en_o),
    .bist_start_o  (bist_start_o),
    .inval_o       (l1_inval_o),
    .fetch_start_o (fetch_start_o),
    .fetch_addr_o  (fetch_addr_o),
    .cfg_o         (cfg_o),
    .err_o         (short_rst_err_o)
  );
endmodule

// File: rtl/bus_reset_sequencer_chk.sv
module bus_reset_sequencer_chk #(
  parameter int unsigned CFG_W   = 4,
  parameter int unsigned TRI_BIT = 0,
  parameter int unsigned ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] RST_VEC = 32'hFFFF_FFF0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_rst_ni,
  input logic              drive_en_o,
  input logic              bist_start_o,
  input logic              l1_inval_o,
  input logic              fetch_start_o,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic [CFG_W-1:0]  cfg_o
);
  // R1
  drv_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(bus_rst_ni, 1) && !$past(bus_rst_ni, 2)) |->
      (!drive_en_o && !bist_start_o && !fetch_start_o));

  // R2
  inval_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l1_inval_o |=> !l1_inval_o);

  // R4
  float_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_en_o |-> !cfg_o[TRI_BIT]);

  // R6
  fetch_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_start_o |=> !fetch_start_o);

  // R7
  fetch_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_start_o |-> (fetch_addr_o == RST_VEC && drive_en_o));

  // R5
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bist_start_o, fetch_start_o, l1_inval_o}));
endmodule

bind bus_reset_sequencer bus_reset_sequencer_chk #(
  .CFG_W(CFG_W), .TRI_BIT(TRI_BIT), .ADDR_W(ADDR_W), .RST_VEC(RST_VEC)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_rst_ni    (bus_rst_ni),
  .drive_en_o    (drive_en_o),
  .bist_start_o  (bist_start_o),
  .l1_inval_o    (l1_inval_o),
  .fetch_start_o (fetch_start_o),
  .fetch_addr_o  (fetch_addr_o),
  .cfg_o         (cfg_o)
);

// File: tb/tb_bus_reset_sequencer.sv
`timescale 1ns/1ps
module tb_bus_reset_sequencer;
  localparam int MIN_HOLD = 16;
  localparam logic [31:0] VEC = 32'hFFFF_FFF0;

  logic clk = 1'b0, rst_ni = 1'b0, bus_rst_ni = 1'b0;
  logic init_strap = 1'b0, bist_done = 1'b0;
  logic [3:0] cfg_strap = 4'h0;
  logic drive_en, bist_start, l1_inval, fetch_start, short_err;
  logic [31:0] fetch_addr;
  logic [3:0] cfg_q;

  always #2.5 clk = ~clk;

  bus_reset_sequencer #(.MIN_HOLD_CYC(MIN_HOLD)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_rst_ni(bus_rst_ni),
    .init_strap_i(init_strap), .cfg_strap_i(cfg_strap), .bist_done_i(bist_done),
    .drive_en_o(drive_en), .bist_start_o(bist_start), .l1_inval_o(l1_inval),
    .fetch_start_o(fetch_start), .fetch_addr_o(fetch_addr), .cfg_o(cfg_q),
    .short_rst_err_o(short_err)
  );

  typedef struct { int kind; string req; } ev_t;  // 1 inval, 2 bist, 3 fetch
  ev_t exp_q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void push(int kind, string req);
    ev_t e;
    e.kind = kind; e.req = req;
    exp_q.push_back(e);
  endfunction

  function automatic void observe(int kind);
    ev_t e;
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL unexpected-event actual=%0d expected=none", kind);
      return;
    end
    e = exp_q.pop_front();
    if (e.kind != kind) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", e.req, kind, e.kind);
    end else if (kind == 3 && fetch_addr !== VEC) begin
      fails++;
      $display("FAIL R7 actual=%h expected=%h", fetch_addr, VEC);
    end
  endfunction

  // monitor
  always @(negedge clk) if (rst_ni) begin
    if (l1_inval) observe(1);
    if (bist_start) observe(2);
    if (fetch_start) observe(3);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic release_bus(logic init, logic [3:0] cfg, logic exp_err);
    init_strap = init; cfg_strap = cfg;
    bus_rst_ni = 1'b1;
    if (cfg[0]) ;
    else if (init) push(2, "R5");
    else push(3, "R6");
    cyc(4);
    chk(cfg[0] ? "R4" : "R7", {63'b0, drive_en}, {63'b0, !cfg[0]});
    chk("R3", {60'b0, cfg_q}, {60'b0, cfg});
    chk("R8", {63'b0, short_err}, {63'b0, exp_err});
    init_strap = ~init; cfg_strap = ~cfg;
    cyc(3);
    chk("R3", {60'b0, cfg_q}, {60'b0, cfg});
  endtask

  task automatic assert_bus();
    bus_rst_ni = 1'b0;
    push(1, "R2");
    cyc(2);
    chk("R1", {61'b0, drive_en, bist_start, fetch_start}, 64'd0);
  endtask

  task automatic reset_pulse(int low, logic init, logic [3:0] cfg);
    assert_bus();
    cyc(low - 2);
    release_bus(init, cfg, low < MIN_HOLD);
  endtask

  initial begin
    cyc(3);
    chk("R10", {drive_en, bist_start, l1_inval, fetch_start, short_err, cfg_q, fetch_addr},
        64'd0);
    push(1, "R2");
    rst_ni = 1'b1;
    cyc(20);
    release_bus(1'b0, 4'b0010, 1'b0);          // direct boot
    chk("R7", {32'b0, fetch_addr}, {32'b0, VEC});

    reset_pulse(20, 1'b1, 4'b0100);            // self-test path
    cyc(5);                                    // no fetch yet: monitor would flag it
    push(3, "R5");
    bist_done = 1'b1; cyc(1); bist_done = 1'b0;
    cyc(3);
    chk("R7", {63'b0, drive_en}, 64'd1);

    reset_pulse(20, 1'b1, 4'b0001);            // float
    cyc(5);
    chk("R4", {63'b0, drive_en}, 64'd0);

    reset_pulse(5, 1'b0, 4'b0110);             // too short
    reset_pulse(MIN_HOLD, 1'b0, 4'b1000);      // exactly long enough clears flag

    // R9: reassertion collides with self-test completion
    reset_pulse(20, 1'b1, 4'b0000);
    assert_bus();
    bist_done = 1'b1; cyc(1); bist_done = 1'b0;
    cyc(20);
    chk("R9", {63'b0, drive_en}, 64'd0);
    release_bus(1'b0, 4'b0000, 1'b0);

    // R9: reassertion during run
    assert_bus();
    cyc(20);
    chk("R9", {63'b0, drive_en}, 64'd0);
    release_bus(1'b0, 4'b0100, 1'b0);

    cyc(5);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL missing-events actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule